// File: doc/BRIEF.md
# Lane-Configurable Carry-Less Multiplier

This block multiplies two 128-bit operand vectors element by element in GF(2): each partial product is an operand bit ANDed with the shifted other operand, and the partial products are merged with XOR. No carries are generated anywhere. An element-width select splits the datapath into two 64-bit lanes or four 32-bit lanes. A low/high select picks which half of each lane's double-width product is returned in that lane's slot of the result.

Operands and both selects are accepted together through a valid/ready handshake. The result leaves through a second valid/ready pair after a fixed two-cycle latency. When the consumer holds off, the whole pipeline stalls and the result is held.

Top module: `clmul_lanes`

## Requirements
- R1: With `wide`=1 and `hi`=0, each 64-bit lane j (bits 64j+63:64j) returns bits 63:0 of the carry-less product of the two operands' lane j.
- R2: With `wide`=1 and `hi`=1, each 64-bit lane returns product bits 126:64 in lane bits 62:0, and lane bit 63 is zero.
- R3: With `wide`=0 and `hi`=0, each 32-bit lane k (bits 32k+31:32k) returns bits 31:0 of the carry-less product of the operands' lane k.
- R4: With `wide`=0 and `hi`=1, each 32-bit lane returns product bits 62:32 in lane bits 30:0, and lane bit 31 is zero.
- R5: Operand bits of one lane affect only that lane's result bits. No value crosses a lane boundary in either width.
- R6: In 64-bit high mode, when either operand of a lane has only its low 32 bits non-zero, the upper 32 bits of that lane's result are zero.
- R7: `wide` and `hi` are captured with the operands on the accepting edge. Later changes do not alter a result already in flight, and back-to-back operations may use different modes.
- R8: An operation presented with `in_valid` and `in_ready` both high in cycle t, with `out_ready` high, appears with `out_valid`=1 in cycle t+2. `out_valid` is 0 in cycle t+1.
- R9: While `out_valid`=1 and `out_ready`=0, `in_ready` is 0 and `result` is held stable. One cycle after `out_ready` rises with no new input, `out_valid` drops.
- R10: While reset is asserted and after it is released, `out_valid` is 0 and `in_ready` is 1 until an operation is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operands and selects are offered |
| in_ready | output | 1 | Block can accept an operation |
| wide | input | 1 | 1: two 64-bit lanes, 0: four 32-bit lanes |
| hi | input | 1 | 1: return upper product half, 0: lower half |
| op_a | input | DW | First operand vector |
| op_b | input | DW | Second operand vector |
| out_valid | output | 1 | Result is available |
| out_ready | input | 1 | Consumer takes the result |
| result | output | DW | Per-lane selected product half |

## Verification
The key corner cases are all-ones operands, single-bit operands at lane edges, and operands confined to one lane. A design that lets a product leak into a neighbouring lane, or that sizes the 32-bit lanes as 64-bit ones, shows non-zero bits where the reference model expects zeros. All-ones operands fill every partial-product row, so a tree that adds instead of XORing produces carry patterns in place of the alternating-bit result. Some mode changes are made after an operation is accepted. A design that reads the live selects at the output stage then returns the wrong half or width. Stalled outputs are watched over several cycles, which catches results that change or are lost while `out_ready` is low.

// File: rtl/clmul_lanes.sv
module clmul_lanes #(
  parameter int DW = 128
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic          wide,
  input  logic          hi,
  input  logic [DW-1:0] op_a,
  input  logic [DW-1:0] op_b,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] result
);
  localparam int NL64 = DW / 64;

  function automatic logic [127:0] cl64(input logic [63:0] x, input logic [63:0] y);
    logic [127:0] r;
    r = '0;
    for (int i = 0; i < 64; i++) r ^= ({64'b0, x} & {128{y[i]}}) << i;
    return r;
  endfunction

  function automatic logic [63:0] cl32(input logic [31:0] x, input logic [31:0] y);
    logic [63:0] r;
    r = '0;
    for (int i = 0; i < 32; i++) r ^= ({32'b0, x} & {64{y[i]}}) << i;
    return r;
  endfunction

  logic          v1, wide1, hi1, wide2, hi2;
  logic [DW-1:0] a1, b1, tree;

  assign in_ready = !(out_valid && !out_ready);

  for (genvar j = 0; j < NL64; j++) begin : g_lane
    logic [63:0]  xa, xb;
    logic [127:0] p;
    logic [63:0]  u;
    assign xa = wide1 ? a1[j*64 +: 64] : {32'b0, a1[j*64 +: 32]};
    assign xb = wide1 ? b1[j*64 +: 64] : {32'b0, b1[j*64 +: 32]};
    assign p  = cl64(xa, xb);
    assign u  = cl32(a1[j*64+32 +: 32], b1[j*64+32 +: 32]);
    assign tree[j*64 +: 64] = wide1 ? (hi1 ? p[127:64] : p[63:0])
                                    : {(hi1 ? u[63:32] : u[31:0]), (hi1 ? p[63:32] : p[31:0])};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v1        <= 1'b0;
      out_valid <= 1'b0;
    end else if (in_ready) begin
      v1        <= in_valid;
      out_valid <= v1;
    end
  end

  always_ff @(posedge clk) begin
    if (in_ready) begin
      a1     <= op_a;
      b1     <= op_b;
      wide1  <= wide;
      hi1    <= hi;
      result <= tree;
      wide2  <= wide1;
      hi2    <= hi1;
    end
  end

  // R9
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(result)));

  // R9
  stall_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  // R2
  wide_top_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && wide2 && hi2) |-> (result[63] == 1'b0 && result[DW-1] == 1'b0));

  // R4
  narrow_top_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !wide2 && hi2) |-> (result[31] == 1'b0 && result[63] == 1'b0));

  // R5
  lane_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (v1 && in_ready && !wide1 && a1[31:0] == 32'b0) |=> (result[31:0] == 32'b0));
endmodule

// File: tb/test_clmul_lanes.sv
module test_clmul_lanes;
  logic         clk = 0, rst_n = 0;
  logic         in_valid = 0, wide = 0, hi = 0, out_ready = 1;
  logic [127:0] op_a = '0, op_b = '0;
  logic         in_ready, out_valid;
  logic [127:0] result;
  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  clmul_lanes #(.DW(128)) i_clmul_lanes (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .wide(wide), .hi(hi), .op_a(op_a), .op_b(op_b),
    .out_valid(out_valid), .out_ready(out_ready), .result(result));

  localparam logic [257:0] VEC [16] = '{
    {128'h0, 128'h0, 1'b1, 1'b0},
    {128'h0, 128'h0, 1'b0, 1'b1},
    {{4{32'hFFFFFFFF}}, {4{32'hFFFFFFFF}}, 1'b1, 1'b0},
    {{4{32'hFFFFFFFF}}, {4{32'hFFFFFFFF}}, 1'b1, 1'b1},
    {{4{32'hFFFFFFFF}}, {4{32'hFFFFFFFF}}, 1'b0, 1'b0},
    {{4{32'hFFFFFFFF}}, {4{32'hFFFFFFFF}}, 1'b0, 1'b1},
    {128'h8000000000000000_8000000000000000, 128'h8000000000000000_0000000000000001, 1'b1, 1'b1},
    {128'h8000000000000000_8000000000000000, 128'h8000000000000000_0000000000000001, 1'b1, 1'b0},
    {128'h80000000_00000001_80000000_80000000, 128'h80000000_80000000_00000001_80000000, 1'b0, 1'b1},
    {128'h80000000_00000001_80000000_80000000, 128'h80000000_80000000_00000001_80000000, 1'b0, 1'b0},
    {128'h0123456789ABCDEF_FEDCBA9876543210, 128'h0F1E2D3C4B5A6978_8796A5B4C3D2E1F0, 1'b1, 1'b0},
    {128'h0123456789ABCDEF_FEDCBA9876543210, 128'h0F1E2D3C4B5A6978_8796A5B4C3D2E1F0, 1'b1, 1'b1},
    {128'h0123456789ABCDEF_FEDCBA9876543210, 128'h0F1E2D3C4B5A6978_8796A5B4C3D2E1F0, 1'b0, 1'b0},
    {128'h0123456789ABCDEF_FEDCBA9876543210, 128'h0F1E2D3C4B5A6978_8796A5B4C3D2E1F0, 1'b0, 1'b1},
    {128'h00000000_DEADBEEF_00000000_FFFFFFFF, 128'h00000000_FFFFFFFF_00000000_CAFEF00D, 1'b1, 1'b1},
    {128'h0, 128'h00000000_00000000_12345678_00000000, 1'b0, 1'b0}
  };

  function automatic logic [127:0] ref_mul(input logic [63:0] x, input logic [63:0] y, input int w);
    logic [127:0] acc = '0;
    for (int i = 0; i < w; i++) if (y[i]) acc = acc ^ ({64'b0, x} << i);
    return acc;
  endfunction

  function automatic logic [127:0] expect_of(input logic [127:0] a, input logic [127:0] b,
                                             input logic w, input logic h);
    logic [127:0] e = '0, p;
    if (w) begin
      for (int j = 0; j < 2; j++) begin
        p = ref_mul(a[j*64 +: 64], b[j*64 +: 64], 64);
        e[j*64 +: 64] = h ? p[127:64] : p[63:0];
      end
    end else begin
      for (int k = 0; k < 4; k++) begin
        p = ref_mul({32'b0, a[k*32 +: 32]}, {32'b0, b[k*32 +: 32]}, 32);
        e[k*32 +: 32] = h ? p[63:32] : p[31:0];
      end
    end
    return e;
  endfunction

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic string req_of(input logic w, input logic h);
    if (w) return h ? "R2" : "R1";
    return h ? "R4" : "R3";
  endfunction

  task automatic run(input logic [127:0] a, input logic [127:0] b, input logic w, input logic h,
                     output logic [127:0] got);
    @(negedge clk);
    op_a = a; op_b = b; wide = w; hi = h; in_valid = 1;
    @(negedge clk);
    in_valid = 0; wide = ~w; hi = ~h; op_a = ~a;
    check("R8 idle cycle", {127'b0, out_valid}, 128'd0);
    @(negedge clk);
    check("R8 valid", {127'b0, out_valid}, 128'd1);
    got = result;
    check(req_of(w, h), result, expect_of(a, b, w, h));
  endtask

  initial begin
    logic [127:0] got, ea, eb, ra, rb;
    repeat (3) @(negedge clk);
    check("R10 reset valid", {127'b0, out_valid}, 128'd0);
    rst_n = 1;
    @(negedge clk);
    check("R10 ready", {126'b0, out_valid, in_ready}, 128'd1);

    for (int i = 0; i < 16; i++) run(VEC[i][257:130], VEC[i][129:2], VEC[i][1], VEC[i][0], got);

    run(128'h3, 128'h3, 1'b1, 1'b0, got);
    check("R1 literal", got, 128'h5);
    run({2{64'hFFFFFFFFFFFFFFFF}}, {2{64'hFFFFFFFFFFFFFFFF}}, 1'b1, 1'b0, got);
    check("R1 all ones", got, {2{64'h5555555555555555}});
    run({2{64'hFFFFFFFFFFFFFFFF}}, {2{64'hFFFFFFFFFFFFFFFF}}, 1'b1, 1'b1, got);
    check("R2 all ones", got, {2{64'h5555555555555555}});
    run({4{32'hFFFFFFFF}}, {4{32'hFFFFFFFF}}, 1'b0, 1'b1, got);
    check("R4 all ones", got, {4{32'h55555555}});

    run(128'hFFFFFFFFFFFFFFFF_FFFFFFFFFFFFFFFF, 128'h00000000FFFFFFFF_00000000ABCD1234, 1'b1, 1'b1, got);
    check("R6 upper zero lane0", {96'b0, got[63:32]}, 128'd0);
    check("R6 upper zero lane1", {96'b0, got[127:96]}, 128'd0);

    run(128'h00000000_FFFFFFFF_00000000_00000000, {4{32'hFFFFFFFF}}, 1'b0, 1'b1, got);
    check("R5 narrow isolation", {got[127:96], got[63:0], 32'b0}, 128'd0);
    run(128'h0000000000000000_FFFFFFFFFFFFFFFF, {4{32'hFFFFFFFF}}, 1'b1, 1'b1, got);
    check("R5 wide isolation", {64'b0, got[127:64]}, 128'd0);

    for (int i = 0; i < 40; i++) begin
      ra = {$urandom, $urandom, $urandom, $urandom};
      rb = {$urandom, $urandom, $urandom, $urandom};
      run(ra, rb, i[0], i[1], got);
    end

    ea = 128'h0F0F0F0F12345678_A5A5A5A5DEADBEEF;
    eb = 128'h13579BDF2468ACE0_FEEDFACE0BADF00D;
    @(negedge clk);
    op_a = ea; op_b = eb; wide = 1; hi = 0; in_valid = 1;
    @(negedge clk);
    op_a = eb; op_b = ea; wide = 0; hi = 1;
    @(negedge clk);
    in_valid = 0; wide = 1; hi = 0; op_a = '0;
    check("R7 first mode", result, expect_of(ea, eb, 1'b1, 1'b0));
    @(negedge clk);
    check("R7 second mode", result, expect_of(eb, ea, 1'b0, 1'b1));
    wide = 0; hi = 1;
    @(negedge clk);
    check("R9 drain", {127'b0, out_valid}, 128'd0);

    out_ready = 0;
    @(negedge clk);
    op_a = ea; op_b = eb; wide = 1; hi = 1; in_valid = 1;
    @(negedge clk);
    in_valid = 0;
    @(negedge clk);
    check("R9 valid under stall", {126'b0, out_valid, in_ready}, 128'd2);
    repeat (3) @(negedge clk);
    check("R9 hold", result, expect_of(ea, eb, 1'b1, 1'b1));
    check("R9 still blocked", {126'b0, out_valid, in_ready}, 128'd2);
    out_ready = 1;
    @(negedge clk);
    check("R9 release", {126'b0, out_valid, in_ready}, 128'd1);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule